// File: doc/BRIEF.md
# NAND Block Lock Guard

This block holds the write-protection state of a NAND flash array and judges each program or erase request against it. It keeps one lock bit per block and a one-way lock-tight flag. Requests arrive as an 8-bit opcode with a decoded block index, qualified by a one-cycle valid strobe. The lock-tight flag freezes the lock map in both directions. Once set, only a power-on reset clears it. It can only be set while the write-protect pin is high, and only if the lock-enable pin was high during reset.

An accepted program or erase produces a one-cycle go pulse for the array sequencer. A rejected one pulls the ready/busy output low for a fixed number of clock cycles and does not run. When the block returns to ready, the status byte shows the block as protected. The status byte is always visible on a port, so a READ STATUS command needs no decoding.

Top module: `blk_protect`

## Requirements
- R1: During and after the synchronous reset (rstN low), every block is locked, lock-tight is off, busyN is 1, opGo is 0 and status reads 8'hC0. Status bit 7 is 1 for "not protected" and bit 6 mirrors busyN; all other bits are 0.
- R2: Opcode 8'h23 (unlock) clears the lock bit of the block given on cmdBlock. Opcode 8'h2A (lock) sets the lock bits of all blocks.
- R3: Opcode 8'h80 (program) or 8'h60 (erase) to an unlocked block is accepted. opGo is 1 for exactly the one cycle after the command, busyN stays 1, and status bit 7 becomes 1 in that same cycle.
- R4: Program or erase to a locked block is rejected. opGo stays 0, and busyN is 0 for exactly LBUSY_CYC cycles, starting in the cycle after the command.
- R5: After a rejection, status bit 7 becomes 0 in the same cycle that busyN returns to 1. It holds 0 until a later request is accepted.
- R6: Opcode 8'h2C (lock tight) sets lock-tight only when wpN is 1 as the command is taken. With wpN at 0 the command has no effect.
- R7: While lock-tight is set, lock (8'h2A) and unlock (8'h23) commands are ignored, so no lock bit changes.
- R8: Lock-tight never clears except through reset. The reset returns every block to the locked state.
- R9: lockPin is sampled while rstN is low. If it was 0, lock-tight commands are ignored until the next reset, whatever lockPin does after reset.
- R10: Any command presented while busyN is 0 is ignored.
- R11: Opcodes other than 8'h23, 8'h2A, 8'h2C, 8'h60 and 8'h80 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous power-on reset, active low |
| lockPin | input | 1 | Lock feature enable, sampled during reset |
| wpN | input | 1 | Write protect, active low |
| cmdValid | input | 1 | One-cycle strobe qualifying cmdOp and cmdBlock |
| cmdOp | input | 8 | Command opcode |
| cmdBlock | input | BLK_W | Decoded block index |
| opGo | output | 1 | One-cycle pulse, program or erase accepted |
| busyN | output | 1 | Ready (1) or busy (0) |
| status | output | 8 | Status byte; bit 7 = not protected, bit 6 = ready |

## Verification
On every cycle, the assertions check four things. The busy interval lasts exactly the configured number of cycles. Status bit 7 is 0 at the moment busy releases. No go pulse appears while busy, and an accepted request leaves status bit 7 set. Lock-tight stays set once set, can never be set when it was disabled at reset, and the lock map cannot change while it is set. Only the bench scenarios can show the rest. These are the opcode decode over all 256 values, the per-block map after patterned unlocks, the write-protect gating of lock-tight, commands dropped during busy, and the state that a reset restores.

// File: rtl/blk_protect_pkg.sv
package blk_protect_pkg;
  localparam logic [7:0] OP_UNLOCK = 8'h23;
  localparam logic [7:0] OP_LOCK   = 8'h2A;
  localparam logic [7:0] OP_TIGHT  = 8'h2C;
  localparam logic [7:0] OP_ERASE  = 8'h60;
  localparam logic [7:0] OP_PROG   = 8'h80;

  // Strobes from the control to the lock map
  typedef struct packed {
    logic lockAll;
    logic unlockOne;
  } mapStrobe_t;
endpackage

// File: rtl/blk_protect_map.sv
module blk_protect_map #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  blk_protect_pkg::mapStrobe_t      strobe,
  input  logic [BLK_W-1:0]                 blkIdx,
  output logic [NUM_BLOCKS-1:0]            lockMap,
  output logic                             blkLocked
);
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)                                          lockMap[i] <= 1'b1;
      else if (strobe.lockAll)                            lockMap[i] <= 1'b1;
      else if (strobe.unlockOne && blkIdx == BLK_W'(i))   lockMap[i] <= 1'b0;
    end
  end

  if (NUM_BLOCKS == (1 << BLK_W)) begin : g_full
    assign blkLocked = lockMap[blkIdx];
  end else begin : g_partial
    // Indices past the last block read as locked
    assign blkLocked = (int'(blkIdx) < NUM_BLOCKS) ? lockMap[blkIdx] : 1'b1;
  end
endmodule

// File: rtl/blk_protect_ctrl.sv
module blk_protect_ctrl #(
  parameter int LBUSY_CYC = 8,
  localparam int CNT_W = $clog2(LBUSY_CYC + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        lockPin,
  input  logic                        wpN,
  input  logic                        cmdValid,
  input  logic [7:0]                  cmdOp,
  input  logic                        blkLocked,
  output blk_protect_pkg::mapStrobe_t strobe,
  output logic                        tightOn,
  output logic                        tightOk,
  output logic                        opGo,
  output logic                        busyN,
  output logic                        notProt
);
  import blk_protect_pkg::*;

  logic [CNT_W-1:0] busyCnt;
  logic             busy;
  logic             take;

  assign busy  = (busyCnt != '0);
  assign busyN = !busy;
  assign take  = cmdValid && !busy;

  always_comb begin
    strobe           = '0;
    strobe.lockAll   = take && !tightOn && (cmdOp == OP_LOCK);
    strobe.unlockOne = take && !tightOn && (cmdOp == OP_UNLOCK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      notProt <= 1'b1;
      opGo    <= 1'b0;
      tightOn <= 1'b0;
      tightOk <= lockPin;
    end else begin
      opGo <= 1'b0;
      if (busy) begin
        busyCnt <= busyCnt - CNT_W'(1);
        if (busyCnt == CNT_W'(1)) notProt <= 1'b0;
      end else if (take) begin
        unique case (cmdOp)
          OP_PROG, OP_ERASE: begin
            if (blkLocked) begin
              busyCnt <= CNT_W'(LBUSY_CYC);
            end else begin
              opGo    <= 1'b1;
              notProt <= 1'b1;
            end
          end
          OP_TIGHT: if (wpN && tightOk) tightOn <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/blk_protect.sv
module blk_protect #(
  parameter int NUM_BLOCKS = 16,
  parameter int LBUSY_CYC  = 8,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockPin,
  input  logic             wpN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdOp,
  input  logic [BLK_W-1:0] cmdBlock,
  output logic             opGo,
  output logic             busyN,
  output logic [7:0]       status
);
  blk_protect_pkg::mapStrobe_t strobe;
  logic [NUM_BLOCKS-1:0]       lockMap;
  logic                        blkLocked;
  logic                        tightOn;
  logic                        tightOk;
  logic                        notProt;

  blk_protect_ctrl #(.LBUSY_CYC(LBUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockPin(lockPin), .wpN(wpN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .blkLocked(blkLocked),
    .strobe(strobe), .tightOn(tightOn), .tightOk(tightOk),
    .opGo(opGo), .busyN(busyN), .notProt(notProt)
  );

  blk_protect_map #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkIdx(cmdBlock),
    .lockMap(lockMap), .blkLocked(blkLocked)
  );

  assign status = {notProt, busyN, 6'b0};
endmodule

// File: rtl/blk_protect_chk.sv
module blk_protect_chk #(
  parameter int NUM_BLOCKS = 16,
  parameter int LBUSY_CYC  = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busyN,
  input logic                  opGo,
  input logic                  protBit,
  input logic                  tightOn,
  input logic                  tightOk,
  input logic [NUM_BLOCKS-1:0] lockMap
);
  logic [31:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       lowCnt <= '0;
    else if (!busyN) lowCnt <= lowCnt + 32'd1;
    else             lowCnt <= '0;
  end

  // R4: busy lasts exactly the configured interval
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (lowCnt == 32'(LBUSY_CYC)));

  // R5: release shows the block protected
  p_release_prot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> !protBit);

  // R10: no launch while busy
  p_no_go_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> !opGo);

  // R3: accepted request reports not protected
  p_go_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    opGo |-> (protBit && busyN));

  // R8: lock-tight is one-way
  p_tight_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    tightOn |=> tightOn);

  // R7: map frozen under lock-tight
  p_map_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    tightOn |=> $stable(lockMap));

  // R9: lock-tight never set when disabled at reset
  p_tight_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !tightOk |-> !tightOn);
endmodule

bind blk_protect blk_protect_chk #(.NUM_BLOCKS(NUM_BLOCKS), .LBUSY_CYC(LBUSY_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .busyN(busyN), .opGo(opGo), .protBit(status[7]),
  .tightOn(tightOn), .tightOk(tightOk), .lockMap(lockMap)
);

// File: tb/sim_blk_protect.sv
`timescale 1ns/1ps
module sim_blk_protect;
  localparam int NB = 8;
  localparam int LB = 5;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lockPin = 1'b1;
  logic          wpN = 1'b1;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdOp = 8'h00;
  logic [BW-1:0] cmdBlock = '0;
  logic          opGo;
  logic          busyN;
  logic [7:0]    status;

  int errors = 0;
  int checks = 0;
  bit expLk [NB];

  always #2 clk = ~clk;

  blk_protect #(.NUM_BLOCKS(NB), .LBUSY_CYC(LB)) u0 (
    .clk(clk), .rstN(rstN), .lockPin(lockPin), .wpN(wpN),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBlock(cmdBlock),
    .opGo(opGo), .busyN(busyN), .status(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input int blk);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdBlock = BW'(blk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitReady();
    for (int n = 0; n < 100 && !busyN; n++) @(negedge clk);
  endtask

  task automatic probe(input int blk, input string req);
    int n;
    issue(blk[0] ? 8'h60 : 8'h80, blk);
    if (expLk[blk]) begin
      check({req, " R4 go"}, int'(opGo), 0);
      n = 0;
      while (!busyN && n < 100) begin n++; @(negedge clk); end
      check({req, " R4 busy len"}, n, LB);
      check({req, " R5 prot"}, int'(status[7]), 0);
    end else begin
      check({req, " R3 go"}, int'(opGo), 1);
      check({req, " R3 ready"}, int'(busyN), 1);
      check({req, " R3 status"}, int'(status[7]), 1);
      @(negedge clk);
      check({req, " R3 pulse"}, int'(opGo), 0);
    end
  endtask

  task automatic probeAll(input string req);
    for (int b = 0; b < NB; b++) probe(b, req);
  endtask

  task automatic doReset(input logic lp);
    @(negedge clk);
    rstN = 1'b0; lockPin = lp; cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", int'(status), 8'hC0);
    rstN = 1'b1;
    lockPin = 1'b1;
    for (int b = 0; b < NB; b++) expLk[b] = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlockPattern(input logic [NB-1:0] pat);
    for (int b = 0; b < NB; b++)
      if (pat[b]) begin issue(8'h23, b); expLk[b] = 1'b0; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] st;
    // R1: reset state
    doReset(1'b1);
    check("R1 status", int'(status), 8'hC0);
    check("R1 busyN", int'(busyN), 1);
    check("R1 opGo", int'(opGo), 0);
    probeAll("R1 all locked");

    // R2: patterned unlocks, then lock all
    unlockPattern(8'hA5);
    probeAll("R2 unlock A5");
    issue(8'h2A, 0);
    for (int b = 0; b < NB; b++) expLk[b] = 1'b1;
    probeAll("R2 lock all");
    unlockPattern(8'h3C);
    probeAll("R2 unlock 3C");

    // R11: every other opcode changes nothing
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h23 || op == 8'h2A || op == 8'h2C || op == 8'h60 || op == 8'h80) continue;
      st = status;
      issue(8'(op), op % NB);
      checks++;
      if (opGo !== 1'b0 || busyN !== 1'b1 || status !== st) begin
        errors++;
        $display("FAIL R11 op %0h: actual=%0h/%0h expected=0/1", op, opGo, status);
      end
    end
    probeAll("R11 map kept");

    // R10: commands during busy are dropped
    issue(8'h80, 0);
    check("R10 busy", int'(busyN), 0);
    issue(8'h23, 0);
    issue(8'h2A, 0);
    waitReady();
    probeAll("R10 map kept");

    // R6: lock tight with wpN low has no effect
    wpN = 1'b0;
    issue(8'h2C, 0);
    unlockPattern(8'h01);
    probe(0, "R6 wp low");
    // R6/R7: with wpN high the map freezes
    wpN = 1'b1;
    issue(8'h2C, 0);
    wpN = 1'b0;
    issue(8'h23, 1);
    probe(1, "R7 unlock ignored");
    issue(8'h2A, 0);
    probeAll("R7 lock ignored");
    issue(8'h23, 7);
    probe(7, "R7 unlock ignored again");

    // R8: only reset clears it, all locked afterwards
    doReset(1'b1);
    probeAll("R8 after reset");
    unlockPattern(8'h02);
    probe(1, "R8 unlock works");

    // R9: lock pin low at reset disables lock tight
    wpN = 1'b1;
    doReset(1'b0);
    issue(8'h2C, 0);
    unlockPattern(8'h08);
    probe(3, "R9 tight disabled");
    issue(8'h2A, 0);
    for (int b = 0; b < NB; b++) expLk[b] = 1'b1;
    probe(3, "R9 lock works");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule